// File: doc/BRIEF.md
# Data Address Translator with Access Protection

This block turns a 32-bit data virtual address into a physical address for a load or a store. Each request carries the address, a write flag and the privilege level of the access. The block first classifies the address by region. Some regions pass through unchanged, some pass through with the top three bits cleared, and some are illegal from user mode. It then applies the global translation-enable control. When translation is needed, it asks an external TLB array through a combinational lookup port and judges the answer against the access type and privilege.

The result is either a physical address or exactly one fault code. It is registered and presented on a response stream one cycle after the request is taken. When a fault comes from the TLB path, the block captures the faulting address in a fault-address register and copies its page-number bits into the upper part of a page-table-entry-high register. The lower part of that register keeps whatever it held before.

Requests use a valid/ready handshake: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The response stream has one stage. `req_ready` is high when that stage is empty, or when its content is being taken in the same cycle (`rsp_ready` high). A response stays on `rsp_paddr`/`rsp_fault`, unchanged, until `rsp_ready` takes it.

Top module: `dat_xlate`

## Requirements
- R1: A privileged access with address bit 31 set is not looked up in these two ranges. From 0xE0000000 upward it returns the address unchanged. Below 0xC0000000 it returns the address with bits 31:29 cleared. Neither range ever faults.
- R2: A user access with address bit 31 set is accepted only in the window 0xE0000000–0xE3FFFFFF, and only while `ctl_sq_user_block` is 0; it then returns the address unchanged. Every other such access faults with code 1 for a read or code 2 for a write. These address errors leave `fault_addr` and `pte_hi` unchanged.
- R3: With `ctl_xlate_en` at 0, every address not covered by R1/R2 returns the address with bits 31:29 cleared, no lookup is issued and no fault is given.
- R4: The lookup asks for an ASID-free match (`tlb_look_any_asid`=1) exactly when `ctl_single_virt` is 1 and the access is privileged; otherwise the external array matches on the current ASID.
- R5: A lookup reporting several matches (`tlb_rsp_multi`) gives code 5. Otherwise a lookup without a match gives code 3 for a read or code 4 for a write.
- R6: A user read that hits an entry without the user flag gives code 6; a privileged read ignores the user flag.
- R7: A privileged write needs the writable flag. A user write needs both the user and the writable flags. A failure gives code 7.
- R8: A write passing R7 to an entry whose dirty flag is clear gives code 8; when both R7 and R8 apply, code 7 is reported.
- R9: A successful translation returns (ppn & mask) | (vaddr & ~mask), where a mask bit of 1 marks a page-number bit.
- R10: Faults 3 to 8 load `fault_addr` with the virtual address and `pte_hi[31:10]` with address bits 31:10, keeping `pte_hi[9:0]`. Without such a fault, `pte_hi_ld` loads `pte_hi` whole from `pte_hi_wdata`.
- R11: A response appears on the edge after acceptance. It is held stable while `rsp_ready` is 0. `req_ready` equals !rsp_valid || rsp_ready.
- R12: After reset `rsp_valid`, `fault_addr` and `pte_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_xlate_en | input | 1 | Translation enable |
| ctl_single_virt | input | 1 | Single-virtual mode: privileged lookups ignore ASID |
| ctl_sq_user_block | input | 1 | 1 closes the store-queue window to user mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_priv | input | 1 | 1 = privileged access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address (0 when faulting) |
| rsp_fault | output | 4 | Fault code, 0 = none |
| tlb_look_valid | output | 1 | Lookup issued this cycle |
| tlb_look_vaddr | output | 32 | Address to look up |
| tlb_look_any_asid | output | 1 | Match without ASID comparison |
| tlb_rsp_hit | input | 1 | At least one entry matches |
| tlb_rsp_multi | input | 1 | More than one entry matches |
| tlb_rsp_ppn | input | 32 | Physical page of the matching entry |
| tlb_rsp_mask | input | 32 | Page-number mask of the matching entry |
| tlb_rsp_user | input | 1 | Entry user-accessible flag |
| tlb_rsp_writable | input | 1 | Entry writable flag |
| tlb_rsp_dirty | input | 1 | Entry dirty flag |
| pte_hi_ld | input | 1 | Load page-table-entry-high register |
| pte_hi_wdata | input | 32 | Data for that load |
| fault_addr | output | 32 | Last TLB-fault virtual address |
| pte_hi | output | 32 | Page-table-entry-high register |

## Verification
The hardest case to reach is when fault checks overlap: a store hitting an entry that is both read-only and clean, where only code 7 may appear. The same goes for an ASID-foreign entry that must be found only under single-virtual privileged access. The bench places purpose-built entries in its own model of the TLB array to create each overlap. It also preloads `pte_hi` with a low-bit pattern before a TLB fault, to show those bits survive. Back-pressure is covered by holding `rsp_ready` low with a request waiting, then comparing the held response and `req_ready` on every clock.

// File: rtl/xl_pkg.sv
package xl_pkg;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_ADDR_RD = 4'd1,
    FLT_ADDR_WR = 4'd2,
    FLT_MISS_RD = 4'd3,
    FLT_MISS_WR = 4'd4,
    FLT_MULTI   = 4'd5,
    FLT_PROT_RD = 4'd6,
    FLT_PROT_WR = 4'd7,
    FLT_INIT_WR = 4'd8
  } fault_e;

  typedef enum logic [1:0] {
    RG_TRANSLATE = 2'd0,
    RG_PASS_RAW  = 2'd1,
    RG_PASS_LOW  = 2'd2,
    RG_ADDR_ERR  = 2'd3
  } region_e;

  // Faults that come out of the TLB path and update the fault registers
  function automatic logic is_tlb_fault(input logic [3:0] code);
    return (code >= 4'd3) && (code <= 4'd8);
  endfunction

endpackage

// File: rtl/xl_region_dec.sv
module xl_region_dec
  import xl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SQ_TAG_W = 6
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              priv,
  input  logic              sq_block,
  input  logic              xlate_en,
  output region_e           kind
);
  localparam logic [2:0]          HI_TOP3 = 3'b111;
  localparam logic [1:0]          HI_TOP2 = 2'b11;
  localparam logic [SQ_TAG_W-1:0] SQ_TAG  = {3'b111, {(SQ_TAG_W-3){1'b0}}};

  logic top_region, in_hi, in_mid, in_sq;

  always_comb begin
    top_region = vaddr[ADDR_W-1];
    in_hi      = (vaddr[ADDR_W-1 -: 3] == HI_TOP3);
    in_mid     = (vaddr[ADDR_W-1 -: 2] == HI_TOP2) && !in_hi;
    in_sq      = (vaddr[ADDR_W-1 -: SQ_TAG_W] == SQ_TAG);
    kind       = RG_TRANSLATE;
    if (top_region) begin
      if (priv) begin
        if (in_hi)        kind = RG_PASS_RAW;
        else if (!in_mid) kind = RG_PASS_LOW;
        else              kind = xlate_en ? RG_TRANSLATE : RG_PASS_LOW;
      end else begin
        kind = (in_sq && !sq_block) ? RG_PASS_RAW : RG_ADDR_ERR;
      end
    end else begin
      kind = xlate_en ? RG_TRANSLATE : RG_PASS_LOW;
    end
  end
endmodule

// File: rtl/xl_perm_chk.sv
module xl_perm_chk
  import xl_pkg::*;
(
  input  logic   write,
  input  logic   priv,
  input  logic   hit,
  input  logic   multi,
  input  logic   user_ok,
  input  logic   writable,
  input  logic   dirty,
  output fault_e fault
);
  logic wr_allowed;

  always_comb begin
    wr_allowed = priv ? writable : (user_ok && writable);
    if (multi)                   fault = FLT_MULTI;
    else if (!hit)               fault = write ? FLT_MISS_WR : FLT_MISS_RD;
    else if (write) begin
      if (!wr_allowed)           fault = FLT_PROT_WR;
      else if (!dirty)           fault = FLT_INIT_WR;
      else                       fault = FLT_NONE;
    end
    else if (!priv && !user_ok)  fault = FLT_PROT_RD;
    else                         fault = FLT_NONE;
  end
endmodule

// File: rtl/xl_fault_regs.sv
module xl_fault_regs #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_vaddr,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_data,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] pte_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr <= '0;
      pte_hi     <= '0;
    end else if (capture) begin
      fault_addr                   <= cap_vaddr;
      pte_hi[ADDR_W-1:PAGE_LSB]    <= cap_vaddr[ADDR_W-1:PAGE_LSB];
    end else if (load) begin
      pte_hi <= load_data;
    end
  end
endmodule

// File: rtl/dat_xlate.sv
module dat_xlate
  import xl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10,
  parameter int FLT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_xlate_en,
  input  logic              ctl_single_virt,
  input  logic              ctl_sq_user_block,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_priv,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [FLT_W-1:0]  rsp_fault,
  output logic              tlb_look_valid,
  output logic [ADDR_W-1:0] tlb_look_vaddr,
  output logic              tlb_look_any_asid,
  input  logic              tlb_rsp_hit,
  input  logic              tlb_rsp_multi,
  input  logic [ADDR_W-1:0] tlb_rsp_ppn,
  input  logic [ADDR_W-1:0] tlb_rsp_mask,
  input  logic              tlb_rsp_user,
  input  logic              tlb_rsp_writable,
  input  logic              tlb_rsp_dirty,
  input  logic              pte_hi_ld,
  input  logic [ADDR_W-1:0] pte_hi_wdata,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] pte_hi
);
  localparam logic [ADDR_W-1:0] LOW_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

  region_e           kind;
  fault_e            flt_chk, flt_nxt;
  logic [ADDR_W-1:0] pa_nxt;
  logic              accept, capture;
  logic              rsp_valid_q;
  logic [ADDR_W-1:0] rsp_paddr_q;
  logic [FLT_W-1:0]  rsp_fault_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  xl_region_dec #(.ADDR_W(ADDR_W)) u_region (
    .vaddr    (req_vaddr),
    .priv     (req_priv),
    .sq_block (ctl_sq_user_block),
    .xlate_en (ctl_xlate_en),
    .kind     (kind)
  );

  assign tlb_look_valid    = accept && (kind == RG_TRANSLATE);
  assign tlb_look_vaddr    = req_vaddr;
  assign tlb_look_any_asid = ctl_single_virt && req_priv;

  xl_perm_chk u_perm (
    .write    (req_write),
    .priv     (req_priv),
    .hit      (tlb_rsp_hit),
    .multi    (tlb_rsp_multi),
    .user_ok  (tlb_rsp_user),
    .writable (tlb_rsp_writable),
    .dirty    (tlb_rsp_dirty),
    .fault    (flt_chk)
  );

  always_comb begin
    flt_nxt = FLT_NONE;
    pa_nxt  = '0;
    case (kind)
      RG_PASS_RAW: pa_nxt = req_vaddr;
      RG_PASS_LOW: pa_nxt = req_vaddr & LOW_MASK;
      RG_ADDR_ERR: flt_nxt = req_write ? FLT_ADDR_WR : FLT_ADDR_RD;
      default: begin
        flt_nxt = flt_chk;
        if (flt_chk == FLT_NONE)
          pa_nxt = (tlb_rsp_ppn & tlb_rsp_mask) | (req_vaddr & ~tlb_rsp_mask);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_paddr_q <= pa_nxt;
      rsp_fault_q <= flt_nxt;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_paddr = rsp_paddr_q;
  assign rsp_fault = rsp_fault_q;

  assign capture = accept && is_tlb_fault(flt_nxt);

  xl_fault_regs #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_fregs (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .cap_vaddr  (req_vaddr),
    .load       (pte_hi_ld),
    .load_data  (pte_hi_wdata),
    .fault_addr (fault_addr),
    .pte_hi     (pte_hi)
  );
endmodule

// File: rtl/xl_chk.sv
module xl_chk
  import xl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10,
  parameter int FLT_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_xlate_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              req_priv,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [FLT_W-1:0]  rsp_fault,
  input logic              tlb_look_valid,
  input logic              pte_hi_ld,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [ADDR_W-1:0] pte_hi
);
  logic took;
  assign took = req_valid && req_ready;

  AST_ACCEPT_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_valid);  // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr));  // R11
  AST_LOOKUP_NEEDS_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_look_valid |-> ctl_xlate_en);  // R3
  AST_NO_LOOKUP_USER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_look_valid |-> (!req_vaddr[ADDR_W-1] || req_priv));  // R2
  AST_PTE_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !pte_hi_ld |=> pte_hi[PAGE_LSB-1:0] == $past(pte_hi[PAGE_LSB-1:0]));  // R10
  AST_FAULT_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (!is_tlb_fault(rsp_fault) || fault_addr == $past(req_vaddr)));  // R10
  AST_PASS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    took && !ctl_xlate_en && !req_vaddr[ADDR_W-1] |=> rsp_fault == '0);  // R3
endmodule

bind dat_xlate xl_chk #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .FLT_W(FLT_W)) u_chk (.*);

// File: tb/dat_xlate_tb_top.sv
`timescale 1ns/1ps
module dat_xlate_tb_top;
  localparam int NE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ctl_xlate_en = 0, ctl_single_virt = 0, ctl_sq_user_block = 0;
  logic req_valid = 0, req_write = 0, req_priv = 0, rsp_ready = 0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_fault;
  logic tlb_look_valid, tlb_look_any_asid;
  logic [31:0] tlb_look_vaddr;
  logic tlb_rsp_hit, tlb_rsp_multi, tlb_rsp_user, tlb_rsp_writable, tlb_rsp_dirty;
  logic [31:0] tlb_rsp_ppn, tlb_rsp_mask;
  logic pte_hi_ld = 0;
  logic [31:0] pte_hi_wdata = '0;
  logic [31:0] fault_addr, pte_hi;

  dat_xlate dut_i (.*);

  // model of the external TLB array
  logic [31:0] e_vpn [NE];
  logic [31:0] e_mask[NE];
  logic [31:0] e_ppn [NE];
  logic [7:0]  e_asid[NE];
  logic        e_v[NE], e_sh[NE], e_u[NE], e_w[NE], e_d[NE];
  logic [7:0]  cur_asid = 8'd5;

  function automatic int hits(input logic [31:0] va, input logic any, output int idx);
    int n = 0;
    idx = 0;
    for (int i = 0; i < NE; i++)
      if (e_v[i] && (e_sh[i] || any || e_asid[i] == cur_asid) &&
          (((e_vpn[i] ^ va) & e_mask[i]) == 32'd0)) begin
        n++;
        idx = i;
      end
    return n;
  endfunction

  always_comb begin
    int n, k;
    n = hits(tlb_look_vaddr, tlb_look_any_asid, k);
    tlb_rsp_hit      = (n >= 1);
    tlb_rsp_multi    = (n > 1);
    tlb_rsp_ppn      = e_ppn[k];
    tlb_rsp_mask     = e_mask[k];
    tlb_rsp_user     = e_u[k];
    tlb_rsp_writable = e_w[k];
    tlb_rsp_dirty    = e_d[k];
  end

  task automatic set_ent(input int i, input logic [31:0] vpn, input logic [31:0] mask,
                         input logic [31:0] ppn, input logic [7:0] asid, input logic sh,
                         input logic u, input logic w, input logic d);
    e_vpn[i] = vpn; e_mask[i] = mask; e_ppn[i] = ppn; e_asid[i] = asid;
    e_v[i] = 1'b1; e_sh[i] = sh; e_u[i] = u; e_w[i] = w; e_d[i] = d;
  endtask

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: address and fault code for one access
  task automatic ref_xlate(input logic [31:0] va, input logic wr, input logic pv,
                           output logic [31:0] pa, output logic [3:0] f, output logic used);
    bit tl = 0;
    int n, k;
    pa = 0; f = 0; used = 0;
    if (va[31]) begin
      if (pv) begin
        if (va >= 32'hE000_0000)      pa = va;
        else if (va < 32'hC000_0000)  pa = va & 32'h1FFF_FFFF;
        else                          tl = 1;
      end else if (va < 32'hE400_0000 && va >= 32'hE000_0000 && !ctl_sq_user_block) pa = va;
      else f = wr ? 4'd2 : 4'd1;
    end else tl = 1;
    if (tl && !ctl_xlate_en) pa = va & 32'h1FFF_FFFF;
    else if (tl) begin
      used = 1;
      n = hits(va, ctl_single_virt && pv, k);
      if (n > 1)       f = 4'd5;
      else if (n == 0) f = wr ? 4'd4 : 4'd3;
      else if (wr) begin
        if (!(pv ? e_w[k] : (e_u[k] && e_w[k]))) f = 4'd7;
        else if (!e_d[k])                       f = 4'd8;
      end else if (!pv && !e_u[k])              f = 4'd6;
      if (f == 0) pa = (e_ppn[k] & e_mask[k]) | (va & ~e_mask[k]);
    end
  endtask

  logic        x_rv = 0;
  logic [31:0] x_pa = 0, x_fa = 0, x_ph = 0;
  logic [3:0]  x_f = 0;

  task automatic step(input string tag, input logic v, input logic [31:0] va, input logic wr,
                      input logic pv, input logic rr, input logic ld = 0,
                      input logic [31:0] ldd = 0);
    logic fire, used;
    logic [31:0] pa;
    logic [3:0] f;
    @(negedge clk);
    req_valid = v; req_vaddr = va; req_write = wr; req_priv = pv; rsp_ready = rr;
    pte_hi_ld = ld; pte_hi_wdata = ldd;
    #1;
    chk("R11", "req_ready", {31'd0, req_ready}, {31'd0, (!x_rv || rr)});
    fire = v && (!x_rv || rr);
    ref_xlate(va, wr, pv, pa, f, used);
    chk(tag, "lookup_valid", {31'd0, tlb_look_valid}, {31'd0, fire && used});
    if (fire && used)
      chk("R4", "any_asid", {31'd0, tlb_look_any_asid}, {31'd0, ctl_single_virt && pv});
    if (fire) begin
      x_rv = 1; x_pa = pa; x_f = f;
    end else if (rr) x_rv = 0;
    if (fire && f >= 3) begin
      x_fa = va; x_ph = {va[31:10], x_ph[9:0]};
    end else if (ld) x_ph = ldd;
    @(posedge clk); #1;
    chk(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, x_rv});
    if (x_rv) begin
      chk(tag, "rsp_fault", {28'd0, rsp_fault}, {28'd0, x_f});
      if (x_f == 0) chk(tag, "rsp_paddr", rsp_paddr, x_pa);
    end
    chk(x_f >= 3 ? "R10" : tag, "fault_addr", fault_addr, x_fa);
    chk(ld ? "R10" : tag, "pte_hi", pte_hi, x_ph);
  endtask

  task automatic done_summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_summary();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      e_v[i] = 0; e_vpn[i] = 0; e_mask[i] = 0; e_ppn[i] = 0; e_asid[i] = 0;
      e_sh[i] = 0; e_u[i] = 0; e_w[i] = 0; e_d[i] = 0;
    end
    set_ent(0, 32'h0040_0000, 32'hFFFF_F000, 32'h0C12_3000, 8'd5, 0, 1, 1, 1);
    set_ent(1, 32'h0080_0000, 32'hFFFF_FC00, 32'h0100_0400, 8'd5, 0, 0, 1, 1);
    set_ent(2, 32'h0090_0000, 32'hFFFF_F000, 32'h0300_0000, 8'd5, 0, 1, 0, 1);
    set_ent(3, 32'h00A0_0000, 32'hFFFF_F000, 32'h0400_0000, 8'd5, 0, 1, 1, 0);
    set_ent(4, 32'h00B0_0000, 32'hFFFF_F000, 32'h0200_0000, 8'd7, 0, 1, 1, 1);
    set_ent(5, 32'h00C0_0000, 32'hFFFF_F000, 32'h0500_0000, 8'd5, 0, 1, 1, 1);
    set_ent(6, 32'h00C0_0000, 32'hFFFF_F000, 32'h0600_0000, 8'd9, 1, 1, 1, 1);
    set_ent(7, 32'hC010_0000, 32'hFFF0_0000, 32'h0A00_0000, 8'd5, 0, 1, 1, 1);
    set_ent(8, 32'h00D0_0000, 32'hFFFF_F000, 32'h0700_0000, 8'd5, 0, 1, 0, 0);

    repeat (3) @(posedge clk);
    #1;
    chk("R12", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12", "fault_addr", fault_addr, 32'd0);
    chk("R12", "pte_hi", pte_hi, 32'd0);
    @(negedge clk); rst_n = 1;
    step("R12", 0, 32'd0, 0, 0, 1);

    // R1: privileged high regions, translation off and on
    step("R1", 1, 32'hE000_1234, 0, 1, 1);
    step("R1", 1, 32'h8C00_1000, 1, 1, 1);
    ctl_xlate_en = 1;
    step("R1", 1, 32'hA000_0010, 0, 1, 1);
    step("R1", 1, 32'hFFFF_FF00, 1, 1, 1);
    // R2: user high region
    step("R2", 1, 32'hE000_0040, 0, 0, 1);
    step("R2", 1, 32'hE3FF_FFFC, 1, 0, 1);
    ctl_sq_user_block = 1;
    step("R2", 1, 32'hE3FF_FFFC, 1, 0, 1);
    ctl_sq_user_block = 0;
    step("R2", 1, 32'h8000_0000, 0, 0, 1);
    step("R2", 1, 32'hC010_0000, 1, 0, 1);
    step("R2", 1, 32'hE400_0000, 0, 0, 1);
    // R3: translation disabled
    ctl_xlate_en = 0;
    step("R3", 1, 32'h0040_0123, 0, 0, 1);
    step("R3", 1, 32'hC010_0000, 1, 1, 1);
    step("R3", 1, 32'h7FFF_FFFF, 1, 0, 1);
    ctl_xlate_en = 1;
    // R9: translation results
    step("R9", 1, 32'h0040_0ABC, 0, 0, 1);
    step("R9", 1, 32'hC010_0ABC, 0, 1, 1);
    step("R9", 1, 32'h0080_03FF, 1, 1, 1);
    // R5: miss and multi-hit
    step("R5", 1, 32'h0050_0000, 0, 0, 1);
    step("R5", 1, 32'h0050_0004, 1, 1, 1);
    step("R5", 1, 32'h00C0_0010, 0, 0, 1);
    // R4: ASID-free match only for privileged single-virtual
    step("R4", 1, 32'h00B0_0004, 0, 0, 1);
    step("R4", 1, 32'h00B0_0004, 0, 1, 1);
    ctl_single_virt = 1;
    step("R4", 1, 32'h00B0_0004, 0, 1, 1);
    step("R4", 1, 32'h00B0_0008, 1, 1, 1);
    step("R4", 1, 32'h00B0_0004, 0, 0, 1);
    ctl_single_virt = 0;
    // R6: user read protection
    step("R6", 1, 32'h0080_0010, 0, 0, 1);
    step("R6", 1, 32'h0080_0010, 0, 1, 1);
    // R7: write protection
    step("R7", 1, 32'h0090_0000, 1, 0, 1);
    step("R7", 1, 32'h0090_0000, 1, 1, 1);
    step("R7", 1, 32'h0080_0010, 1, 0, 1);
    step("R7", 1, 32'h0080_0010, 1, 1, 1);
    // R8: clean page writes, ordering after R7
    step("R8", 1, 32'h00A0_0020, 1, 0, 1);
    step("R8", 1, 32'h00A0_0020, 0, 0, 1);
    step("R8", 1, 32'h00D0_0020, 1, 1, 1);
    // R10: preload low bits, then TLB fault, then address error leaves regs
    step("R10", 0, 32'd0, 0, 0, 1, 1, 32'h1234_57A5);
    step("R10", 1, 32'h0060_1FFF, 1, 0, 1);
    step("R10", 1, 32'h9000_0000, 1, 0, 1);
    step("R10", 1, 32'h0040_0000, 0, 0, 1);
    // R11: back-pressure with waiting requests
    step("R11", 1, 32'h0040_0004, 0, 0, 0);
    step("R11", 1, 32'h0050_0000, 0, 0, 0);
    step("R11", 1, 32'h0050_0000, 0, 0, 0);
    step("R11", 1, 32'h0050_0000, 0, 0, 1);
    step("R11", 0, 32'd0, 0, 0, 1);
    step("R11", 0, 32'd0, 0, 0, 1);
    done_summary();
  end
endmodule